// File: doc/BRIEF.md
# Script Transfer-Control Branch Unit

This block resolves one transfer-control instruction of a script sequencer. The instruction class is the one whose two top opcode bits read binary 10. The sequencer presents the instruction word, its 32-bit argument and the address of the instruction. It also presents the live bus phase, the arithmetic carry and the first-byte register, then pulses `start`. One clock later the unit reports whether the branch was taken, the next program pointer, and any interrupt event. It also reports whether the sequencer must halt.

The condition is a chain of up to three tests: carry, bus phase and masked data. They are combined under a selectable sense. A jump-if-true instruction is taken only when every enabled test is true. A jump-if-false instruction is taken only when every enabled test is false. Evaluation stops at the first test that breaks the sense. The unit also holds the return-address register, which a call loads and a return reads back.

Top module: `tc_branch_unit`

## Requirements
- R1: After a synchronous active-low reset, `done`, `halt`, `taken`, the three event outputs, `next_pc` and `temp` are all zero.
- R2: `done` is high in exactly the cycle after a cycle in which `start` was high, and low otherwise.
- R3: When insn bits 21, 19, 18 and 17 are all zero, the branch is taken regardless of carry, phase and first-byte inputs.
- R4: Insn bit 19 is the sense (1 = jump if true, 0 = jump if false). The result starts equal to the sense, and each enabled test runs only while the result still equals the sense. The branch is taken when the final result equals the sense, so that a true-sense branch needs every enabled test true and a false-sense branch needs every enabled test false.
- R5: Insn bit 21 enables a carry test whose outcome is true when `carry` is 1.
- R6: Insn bit 17 enables a phase test whose outcome is true when `phase` equals insn bits 26:24.
- R7: Insn bit 18 enables a data test whose outcome is true when `first_byte` and insn bits 7:0 agree on every bit where insn bits 15:8 are zero.
- R8: With insn bit 23 clear the target is `arg`. With bit 23 set the target is `pc_in + 8` plus `arg[23:0]` sign-extended.
- R9: Insn bits 29:27 select the operation when taken. Code 0 sets `next_pc` to the target. Code 1 does the same and loads `temp` with `pc_in + 8`. Code 2 sets `next_pc` to `temp`. `temp` changes only on a taken call.
- R10: A taken code 3 with insn bit 20 set pulses `int_fly` and continues with `next_pc = pc_in + 8` and no halt. With bit 20 clear it pulses `int_script` and halts, with `next_pc = pc_in + 8`.
- R11: A taken branch with code 4 to 7 pulses `int_illegal` and halts, with `next_pc = pc_in + 8`.
- R12: When `sel_timeout` is high at `start`, the unit halts without evaluating. In that case `next_pc = pc_in`, `taken` is 0, no event is raised and `temp` is unchanged.
- R13: A branch that is not taken gives `next_pc = pc_in + 8`, `taken` 0, no halt and no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Evaluate the presented instruction this cycle |
| insn | input | 32 | Instruction word |
| arg | input | 32 | Instruction argument (target or offset) |
| pc_in | input | 32 | Address of this instruction |
| phase | input | 3 | Current bus phase |
| carry | input | 1 | Arithmetic carry flag |
| first_byte | input | 8 | First-byte register value |
| sel_timeout | input | 1 | A selection timeout is pending |
| done | output | 1 | Result valid (one cycle after start) |
| taken | output | 1 | Condition met and operation performed |
| halt | output | 1 | Sequencer must stop |
| next_pc | output | 32 | Next program pointer |
| temp | output | 32 | Return-address register |
| int_fly | output | 1 | Interrupt-on-the-fly event |
| int_script | output | 1 | Script-interrupt event |
| int_illegal | output | 1 | Illegal-instruction event |

## Verification
The hardest case to reach is the short-circuit of the chain, where a later test would have passed but must not be consulted. The stimulus enables carry and phase together. It makes the carry test break the sense while the phase matches, and it does this under both senses. A separate run leaves both tests consistent with the sense, so the branch is taken. A return is also checked right after a call, so that a wrong value saved in `temp` shows up through `next_pc`.

// File: rtl/tc_pkg.sv
// Shared constants for the transfer-control branch unit.
// Assumes the caller decodes the instruction class before asserting start.
package tc_pkg;
    localparam int OP_LSB      = 27;
    localparam int OP_W        = 3;
    localparam logic [2:0] OP_JUMP = 3'd0;
    localparam logic [2:0] OP_CALL = 3'd1;
    localparam logic [2:0] OP_RET  = 3'd2;
    localparam logic [2:0] OP_INT  = 3'd3;
    localparam int BIT_CARRY   = 21;
    localparam int BIT_FLYINT  = 20;
    localparam int BIT_SENSE   = 19;
    localparam int BIT_DATA    = 18;
    localparam int BIT_PHASE   = 17;
    localparam int BIT_REL     = 23;
    localparam int OFFSET_W    = 24;
    localparam int INSN_BYTES  = 8;
endpackage

// File: rtl/tc_cond_eval.sv
// Condition chain: carry, phase, then masked data test, each run only while
// the running result still equals the sense. Purely combinational.
// Assumes phase and data fields are already extracted by the caller.
module tc_cond_eval #(
    parameter int PHASE_W = 3,
    parameter int DATA_W  = 8
) (
    input  logic               sense,
    input  logic               en_carry,
    input  logic               en_phase,
    input  logic               en_data,
    input  logic               carry,
    input  logic [PHASE_W-1:0] phase,
    input  logic [PHASE_W-1:0] want_phase,
    input  logic [DATA_W-1:0]  first_byte,
    input  logic [DATA_W-1:0]  want_data,
    input  logic [DATA_W-1:0]  ignore_mask,
    output logic               pass
);
    logic [DATA_W-1:0] care;
    logic              result;

    // Walk the chain in fixed order, skipping tests once the sense is broken.
    always_comb begin
        care   = ~ignore_mask;
        result = sense;
        if (en_carry && (result == sense))
            result = carry;
        if (en_phase && (result == sense))
            result = (phase == want_phase);
        if (en_data && (result == sense))
            result = ((first_byte & care) == (want_data & care));
        pass = (result == sense);
    end
endmodule

// File: rtl/tc_target_calc.sv
// Branch target and fall-through address. The relative form adds a
// sign-extended 24-bit offset to the address of the following instruction.
module tc_target_calc #(
    parameter int ADDR_W     = 32,
    parameter int OFFSET_W   = 24,
    parameter int INSN_BYTES = 8
) (
    input  logic [ADDR_W-1:0] pc_in,
    input  logic [ADDR_W-1:0] arg,
    input  logic              relative,
    output logic [ADDR_W-1:0] fall_pc,
    output logic [ADDR_W-1:0] target
);
    localparam int EXT_W = ADDR_W - OFFSET_W;
    logic [ADDR_W-1:0] offset_sx;

    // Form the fall-through address and select the absolute or relative target.
    always_comb begin
        fall_pc   = pc_in + ADDR_W'(INSN_BYTES);
        offset_sx = {{EXT_W{arg[OFFSET_W-1]}}, arg[OFFSET_W-1:0]};
        target    = relative ? (fall_pc + offset_sx) : arg;
    end
endmodule

// File: rtl/tc_branch_unit.sv
// Transfer-control branch unit. Evaluates one instruction per start pulse and
// registers the outcome one cycle later. Holds the return-address register.
// Assumes start is only raised for instructions of the transfer-control class.
module tc_branch_unit
    import tc_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int INSN_W  = 32,
    parameter int PHASE_W = 3,
    parameter int DATA_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [INSN_W-1:0]  insn,
    input  logic [ADDR_W-1:0]  arg,
    input  logic [ADDR_W-1:0]  pc_in,
    input  logic [PHASE_W-1:0] phase,
    input  logic               carry,
    input  logic [DATA_W-1:0]  first_byte,
    input  logic               sel_timeout,
    output logic               done,
    output logic               taken,
    output logic               halt,
    output logic [ADDR_W-1:0]  next_pc,
    output logic [ADDR_W-1:0]  temp,
    output logic               int_fly,
    output logic               int_script,
    output logic               int_illegal
);
    logic              pass;
    logic [ADDR_W-1:0] fall_pc, target;
    logic [OP_W-1:0]   op;
    logic              unused_bits;

    assign op          = insn[OP_LSB +: OP_W];
    assign unused_bits = ^{insn[31:30], insn[22], insn[16]};

    tc_cond_eval #(.PHASE_W(PHASE_W), .DATA_W(DATA_W)) u_cond (
        .sense       (insn[BIT_SENSE]),
        .en_carry    (insn[BIT_CARRY]),
        .en_phase    (insn[BIT_PHASE]),
        .en_data     (insn[BIT_DATA]),
        .carry       (carry),
        .phase       (phase),
        .want_phase  (insn[24 +: PHASE_W]),
        .first_byte  (first_byte),
        .want_data   (insn[0 +: DATA_W]),
        .ignore_mask (insn[DATA_W +: DATA_W]),
        .pass        (pass)
    );

    tc_target_calc #(.ADDR_W(ADDR_W), .OFFSET_W(OFFSET_W), .INSN_BYTES(INSN_BYTES)) u_tgt (
        .pc_in    (pc_in),
        .arg      (arg),
        .relative (insn[BIT_REL]),
        .fall_pc  (fall_pc),
        .target   (target)
    );

    // Register the outcome of the instruction presented with start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0; taken <= 1'b0; halt <= 1'b0;
            next_pc <= '0; temp <= '0;
            int_fly <= 1'b0; int_script <= 1'b0; int_illegal <= 1'b0;
        end else begin
            done <= start;
            int_fly <= 1'b0; int_script <= 1'b0; int_illegal <= 1'b0;
            if (start) begin
                taken   <= 1'b0;
                halt    <= 1'b0;
                next_pc <= fall_pc;
                if (sel_timeout) begin
                    halt    <= 1'b1;
                    next_pc <= pc_in;
                end else if (pass) begin
                    taken <= 1'b1;
                    case (op)
                        OP_JUMP: next_pc <= target;
                        OP_CALL: begin
                            next_pc <= target;
                            temp    <= fall_pc;
                        end
                        OP_RET:  next_pc <= temp;
                        OP_INT: begin
                            if (insn[BIT_FLYINT]) int_fly <= 1'b1;
                            else begin
                                int_script <= 1'b1;
                                halt       <= 1'b1;
                            end
                        end
                        default: begin
                            int_illegal <= 1'b1;
                            halt        <= 1'b1;
                        end
                    endcase
                end
            end
        end
    end

    // R2
    done_follows_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done);
    // R2
    no_spurious_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !done);
    // R12
    timeout_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && sel_timeout) |=> (halt && !taken && next_pc == $past(pc_in)));
    // R9
    temp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> $stable(temp));
    // R11
    illegal_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_illegal |-> (halt && done));
    // R10
    one_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({int_fly, int_script, int_illegal}));
endmodule

// File: tb/tc_branch_unit_test.sv
module tc_branch_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] insn = '0, arg = '0, pc_in = '0;
    logic [2:0]  phase = '0;
    logic        carry = 1'b0;
    logic [7:0]  first_byte = '0;
    logic        sel_timeout = 1'b0;
    logic        done, taken, halt, int_fly, int_script, int_illegal;
    logic [31:0] next_pc, temp;
    int n_run = 0, n_fail = 0;

    always #4 clk = ~clk;

    tc_branch_unit uut (
        .clk(clk), .rst_n(rst_n), .start(start), .insn(insn), .arg(arg),
        .pc_in(pc_in), .phase(phase), .carry(carry), .first_byte(first_byte),
        .sel_timeout(sel_timeout), .done(done), .taken(taken), .halt(halt),
        .next_pc(next_pc), .temp(temp), .int_fly(int_fly),
        .int_script(int_script), .int_illegal(int_illegal)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Issue one instruction and sample results one edge later.
    task automatic issue(input logic [31:0] i, input logic [31:0] a, input logic [31:0] pc,
                         input logic [2:0] ph, input logic cy, input logic [7:0] fb,
                         input logic sto);
        @(negedge clk);
        insn = i; arg = a; pc_in = pc; phase = ph; carry = cy;
        first_byte = fb; sel_timeout = sto; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Compare the full result vector of the last issue.
    task automatic expect_res(input string req, input logic tk, input logic hl,
                              input logic [31:0] pc, input logic [2:0] ev);
        chk(req, {31'd0, done}, 32'd1);
        chk(req, {31'd0, taken}, {31'd0, tk});
        chk(req, {31'd0, halt}, {31'd0, hl});
        chk(req, next_pc, pc);
        chk(req, {29'd0, int_fly, int_script, int_illegal}, {29'd0, ev});
    endtask

    task automatic t_reset();
        chk("R1 done", {31'd0, done}, 32'd0);
        chk("R1 next_pc", next_pc, 32'd0);
        chk("R1 temp", temp, 32'd0);
        chk("R1 flags", {27'd0, taken, halt, int_fly, int_script, int_illegal}, 32'd0);
    endtask

    task automatic t_uncond();
        // R3: no test bits, carry/phase/data irrelevant
        issue(32'h8000_0000, 32'h0000_1000, 32'h200, 3'd5, 1'b0, 8'h00, 1'b0);
        expect_res("R3 uncond jump", 1'b1, 1'b0, 32'h1000, 3'b000);
        @(negedge clk);
        chk("R2 done drops", {31'd0, done}, 32'd0);
    endtask

    task automatic t_relative();
        // R8 negative offset -16 from 0x408
        issue(32'h8080_0000, 32'h00FF_FFF0, 32'h400, 3'd0, 1'b0, 8'h00, 1'b0);
        expect_res("R8 rel neg", 1'b1, 1'b0, 32'h3F8, 3'b000);
        // R8 positive offset, upper arg byte ignored
        issue(32'h8080_0000, 32'hAB00_0020, 32'h400, 3'd0, 1'b0, 8'h00, 1'b0);
        expect_res("R8 rel pos", 1'b1, 1'b0, 32'h428, 3'b000);
    endtask

    task automatic t_call_ret();
        issue(32'h8800_0000, 32'h0000_2000, 32'h300, 3'd0, 1'b0, 8'h00, 1'b0);
        expect_res("R9 call", 1'b1, 1'b0, 32'h2000, 3'b000);
        chk("R9 call temp", temp, 32'h308);
        issue(32'h9000_0000, 32'h0000_5555, 32'h2100, 3'd0, 1'b0, 8'h00, 1'b0);
        expect_res("R9 return", 1'b1, 1'b0, 32'h308, 3'b000);
        chk("R9 temp kept", temp, 32'h308);
    endtask

    task automatic t_carry();
        issue(32'h8028_0000, 32'h0000_0700, 32'h100, 3'd0, 1'b1, 8'h00, 1'b0);
        expect_res("R5 carry true", 1'b1, 1'b0, 32'h700, 3'b000);
        issue(32'h8028_0000, 32'h0000_0700, 32'h100, 3'd0, 1'b0, 8'h00, 1'b0);
        expect_res("R13 carry false not taken", 1'b0, 1'b0, 32'h108, 3'b000);
        issue(32'h8020_0000, 32'h0000_0700, 32'h100, 3'd0, 1'b0, 8'h00, 1'b0);
        expect_res("R4 jump-if-false carry clear", 1'b1, 1'b0, 32'h700, 3'b000);
    endtask

    task automatic t_phase();
        issue(32'h830A_0000, 32'h0000_0900, 32'h100, 3'd3, 1'b0, 8'h00, 1'b0);
        expect_res("R6 phase match", 1'b1, 1'b0, 32'h900, 3'b000);
        issue(32'h830A_0000, 32'h0000_0900, 32'h100, 3'd2, 1'b0, 8'h00, 1'b0);
        expect_res("R6 phase mismatch", 1'b0, 1'b0, 32'h108, 3'b000);
    endtask

    task automatic t_data();
        // R7: mask byte F0 -> only low nibble compared against A
        issue(32'h800C_F05A, 32'h0000_0A00, 32'h100, 3'd0, 1'b0, 8'h3A, 1'b0);
        expect_res("R7 data masked match", 1'b1, 1'b0, 32'hA00, 3'b000);
        issue(32'h800C_F05A, 32'h0000_0A00, 32'h100, 3'd0, 1'b0, 8'h3B, 1'b0);
        expect_res("R7 data mismatch", 1'b0, 1'b0, 32'h108, 3'b000);
    endtask

    task automatic t_chain();
        // R4 true sense: carry breaks sense, matching phase not consulted
        issue(32'h832A_0000, 32'h0000_0B00, 32'h100, 3'd3, 1'b0, 8'h00, 1'b0);
        expect_res("R4 chain true-sense stop", 1'b0, 1'b0, 32'h108, 3'b000);
        // R4 false sense: carry set breaks sense
        issue(32'h8322_0000, 32'h0000_0B00, 32'h100, 3'd5, 1'b1, 8'h00, 1'b0);
        expect_res("R4 chain false-sense stop", 1'b0, 1'b0, 32'h108, 3'b000);
        // R4 false sense: both tests false -> taken
        issue(32'h8322_0000, 32'h0000_0B00, 32'h100, 3'd5, 1'b0, 8'h00, 1'b0);
        expect_res("R4 chain false-sense taken", 1'b1, 1'b0, 32'hB00, 3'b000);
    endtask

    task automatic t_interrupts();
        issue(32'h9810_0000, 32'h0, 32'h500, 3'd0, 1'b0, 8'h00, 1'b0);
        expect_res("R10 on-the-fly", 1'b1, 1'b0, 32'h508, 3'b100);
        issue(32'h9800_0000, 32'h0, 32'h500, 3'd0, 1'b0, 8'h00, 1'b0);
        expect_res("R10 script int", 1'b1, 1'b1, 32'h508, 3'b010);
        issue(32'h9828_0000, 32'h0, 32'h500, 3'd0, 1'b0, 8'h00, 1'b0);
        expect_res("R13 int not taken", 1'b0, 1'b0, 32'h508, 3'b000);
        issue(32'hA000_0000, 32'h0, 32'h600, 3'd0, 1'b0, 8'h00, 1'b0);
        expect_res("R11 illegal op4", 1'b1, 1'b1, 32'h608, 3'b001);
        issue(32'hB800_0000, 32'h0, 32'h600, 3'd0, 1'b0, 8'h00, 1'b0);
        expect_res("R11 illegal op7", 1'b1, 1'b1, 32'h608, 3'b001);
    endtask

    task automatic t_timeout();
        issue(32'h8800_0000, 32'h0000_4000, 32'h700, 3'd0, 1'b0, 8'h00, 1'b1);
        expect_res("R12 timeout halt", 1'b0, 1'b1, 32'h700, 3'b000);
        chk("R12 temp unchanged", temp, 32'h308);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_uncond();
        t_relative();
        t_call_ret();
        t_carry();
        t_phase();
        t_data();
        t_chain();
        t_interrupts();
        t_timeout();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #100000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule